// File: doc/BRIEF.md
# Two-Operand ALU with Carry Flag

This block is the arithmetic and logic stage of a small two-operand register machine. Each operation has the form d = f(d, s). The second operand s is either a register value or a short unsigned literal. A 4-bit operation code picks one of sixteen functions: plain and carry-writing arithmetic, bitwise logic, shifts, and rotates through the carry flag. The result, the proposed next carry and the carry write request are all combinational outputs.

A thin registered wrapper holds the one-bit carry flag. The instruction condition is evaluated from a zero flag for the test register, which the caller captures at the start of the instruction, and from a polarity select. The stored carry changes only when the condition passes and the operation asks to write carry. The caller uses the commit output to gate its own register-file write of the result.

Top module: `twoop_alu`

## Requirements
- R1: While rst is high, the stored carry carry_q is cleared to 0 on each clock edge.
- R2: Op codes 0 (adn: d+s), 1 (sbn: d-s), 2 (mov: s) and 3 (neg: 0-s) give their 16-bit results modulo 2^16 with carry_we low and carry_next equal to carry_q.
- R3: Op codes 4 (add: d+s) and 5 (sub: d-s) raise carry_we. For add, carry_next is the carry out of bit 15. For sub, carry_next is the borrow, which is 1 exactly when d < s unsigned.
- R4: Op code 6 (adc) gives d+s+carry_q and op code 7 (sbb) gives d-s-carry_q, both with carry_we high. For sbb the borrow is 1 exactly when d < s+carry_q unsigned.
- R5: Op codes 8 (and), 9 (or) and 10 (xor) combine d with s bitwise, and op code 11 (inv) gives ~s. All four leave carry_we low.
- R6: Op code 12 (sr) gives {carry_q, s[15:1]} and op code 13 (sl) gives {s[14:0], 0}. Both leave carry_we low.
- R7: Op code 14 (rrc) gives {carry_q, s[15:1]} with carry_next = s[0]. Op code 15 (rlc) gives {s[14:0], carry_q} with carry_next = s[15]. Both raise carry_we.
- R8: When use_lit is high, s is s_lit zero-extended to 16 bits and s_reg is ignored. Otherwise s is s_reg.
- R9: commit is high when cond_nz is 0 and ts_zero is 1, or when cond_nz is 1 and ts_zero is 0.
- R10: On a clock edge out of reset, carry_q takes carry_next only when commit and carry_we are both high. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| d_val | input | 16 | Destination operand value |
| s_reg | input | 16 | Register source operand |
| s_lit | input | 4 | Literal source operand |
| use_lit | input | 1 | Select the literal as source |
| ts_zero | input | 1 | Test register was zero at instruction start |
| cond_nz | input | 1 | Condition polarity: 1 = store on nonzero |
| result | output | 16 | Operation result |
| carry_next | output | 1 | Proposed new carry |
| carry_we | output | 1 | Operation writes carry |
| commit | output | 1 | Condition passed |
| carry_q | output | 1 | Stored carry flag |

## Verification
The only internal state is the carry flag. A wrong flag shows up at the ports one clock after the faulty update: carry_q itself changes, and so do the results of adc, sbb, sr, rrc and rlc in the very next operation. The bench therefore chains carry-consuming operations after carry-producing ones, with random conditions, and compares carry_q after every edge. A stale flag or a flag updated on a failed condition is then caught within a single cycle.

// File: rtl/twoop_pkg.sv
package twoop_pkg;
    parameter int DATA_W = 16;
    parameter int LIT_W  = 4;
    parameter int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADN = 4'd0,  OP_SBN = 4'd1,  OP_MOV = 4'd2,  OP_NEG = 4'd3,
        OP_ADD = 4'd4,  OP_SUB = 4'd5,  OP_ADC = 4'd6,  OP_SBB = 4'd7,
        OP_AND = 4'd8,  OP_OR  = 4'd9,  OP_XOR = 4'd10, OP_INV = 4'd11,
        OP_SR  = 4'd12, OP_SL  = 4'd13, OP_RRC = 4'd14, OP_RLC = 4'd15
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              cout;
        logic              cwe;
    } alu_out_t;

    // Upper half of the op space holds the bit-level operations.
    function automatic logic is_bitop(op_e o);
        return o[OP_W-1];
    endfunction
endpackage

// File: rtl/twoop_src_mux.sv
module twoop_src_mux
    import twoop_pkg::*;
(
    input  logic [DATA_W-1:0] s_reg,
    input  logic [LIT_W-1:0]  s_lit,
    input  logic              use_lit,
    output logic [DATA_W-1:0] s_eff
);
    localparam int PAD_W = DATA_W - LIT_W;

    always_comb begin
        if (use_lit) s_eff = {{PAD_W{1'b0}}, s_lit};
        else         s_eff = s_reg;
    end
endmodule

// File: rtl/twoop_arith.sv
module twoop_arith
    import twoop_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] d,
    input  logic [DATA_W-1:0] s,
    input  logic              cin,
    output alu_out_t          out
);
    localparam int SUM_W = DATA_W + 1;

    logic              sub_mode, zero_a, use_cin, we;
    logic [DATA_W-1:0] a_in, b_in;
    logic              c_in_eff;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        sub_mode = 1'b0;
        zero_a   = 1'b0;
        use_cin  = 1'b0;
        we       = 1'b0;
        case (op)
            OP_SBN: sub_mode = 1'b1;
            OP_MOV: zero_a   = 1'b1;
            OP_NEG: begin zero_a = 1'b1; sub_mode = 1'b1; end
            OP_ADD: we = 1'b1;
            OP_SUB: begin sub_mode = 1'b1; we = 1'b1; end
            OP_ADC: begin use_cin = 1'b1; we = 1'b1; end
            OP_SBB: begin sub_mode = 1'b1; use_cin = 1'b1; we = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        a_in = zero_a ? '0 : d;
        b_in = sub_mode ? ~s : s;
        // Subtraction adds the complement plus one, minus any borrow-in.
        if (sub_mode) c_in_eff = use_cin ? ~cin : 1'b1;
        else          c_in_eff = use_cin ? cin : 1'b0;
        sum = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, c_in_eff};
    end

    always_comb begin
        out.value = sum[DATA_W-1:0];
        out.cwe   = we;
        if (we) out.cout = sub_mode ? ~sum[DATA_W] : sum[DATA_W];
        else    out.cout = cin;
    end
endmodule

// File: rtl/twoop_bitops.sv
module twoop_bitops
    import twoop_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] d,
    input  logic [DATA_W-1:0] s,
    input  logic              cin,
    output alu_out_t          out
);
    always_comb begin
        out.value = '0;
        out.cout  = cin;
        out.cwe   = 1'b0;
        case (op)
            OP_AND: out.value = d & s;
            OP_OR:  out.value = d | s;
            OP_XOR: out.value = d ^ s;
            OP_INV: out.value = ~s;
            OP_SR:  out.value = {cin, s[DATA_W-1:1]};
            OP_SL:  out.value = {s[DATA_W-2:0], 1'b0};
            OP_RRC: begin
                out.value = {cin, s[DATA_W-1:1]};
                out.cout  = s[0];
                out.cwe   = 1'b1;
            end
            OP_RLC: begin
                out.value = {s[DATA_W-2:0], cin};
                out.cout  = s[DATA_W-1];
                out.cwe   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/twoop_alu.sv
module twoop_alu
    import twoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] d_val,
    input  logic [DATA_W-1:0] s_reg,
    input  logic [LIT_W-1:0]  s_lit,
    input  logic              use_lit,
    input  logic              ts_zero,
    input  logic              cond_nz,
    output logic [DATA_W-1:0] result,
    output logic              carry_next,
    output logic              carry_we,
    output logic              commit,
    output logic              carry_q
);
    op_e               op_t;
    logic [DATA_W-1:0] s_eff;
    alu_out_t          arith_o, bit_o, sel_o;

    assign op_t = op_e'(op);

    twoop_src_mux u_src (
        .s_reg   (s_reg),
        .s_lit   (s_lit),
        .use_lit (use_lit),
        .s_eff   (s_eff)
    );

    twoop_arith u_arith (
        .op  (op_t),
        .d   (d_val),
        .s   (s_eff),
        .cin (carry_q),
        .out (arith_o)
    );

    twoop_bitops u_bits (
        .op  (op_t),
        .d   (d_val),
        .s   (s_eff),
        .cin (carry_q),
        .out (bit_o)
    );

    assign sel_o      = is_bitop(op_t) ? bit_o : arith_o;
    assign result     = sel_o.value;
    assign carry_next = sel_o.cout;
    assign carry_we   = sel_o.cwe;
    assign commit     = cond_nz ? ~ts_zero : ts_zero;

    always_ff @(posedge clk) begin
        if (rst)                   carry_q <= 1'b0;
        else if (commit && carry_we) carry_q <= carry_next;
    end
endmodule

// File: rtl/twoop_alu_chk.sv
module twoop_alu_chk
    import twoop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] d_val,
    input logic [DATA_W-1:0] s_reg,
    input logic [LIT_W-1:0]  s_lit,
    input logic              use_lit,
    input logic              ts_zero,
    input logic              cond_nz,
    input logic [DATA_W-1:0] result,
    input logic              carry_next,
    input logic              carry_we,
    input logic              commit,
    input logic              carry_q
);
    logic [DATA_W-1:0] s_chk;
    assign s_chk = use_lit ? DATA_W'(s_lit) : s_reg;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !carry_q);

    assert_no_carry_write_R2: assert property (@(posedge clk) disable iff (rst)
        (op < 4'd4) |-> (!carry_we && carry_next == carry_q));

    assert_xor_value_R5: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd10) |-> (result == (d_val ^ s_chk) && !carry_we));

    assert_shift_left_R6: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd13) |-> (!result[0] && !carry_we));

    assert_rrc_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd14) |-> (carry_we && carry_next == s_chk[0]
                           && result[DATA_W-1] == carry_q));

    assert_cond_eval_R9: assert property (@(posedge clk) disable iff (rst)
        commit == (cond_nz != ts_zero));

    assert_carry_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(commit && carry_we) |=> $stable(carry_q));

    assert_carry_load_R10: assert property (@(posedge clk) disable iff (rst)
        (commit && carry_we) |=> (carry_q == $past(carry_next)));
endmodule

bind twoop_alu twoop_alu_chk u_chk (.*);

// File: tb/twoop_alu_bench.sv
`timescale 1ns/1ps
module twoop_alu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic [15:0] d_val, s_reg;
    logic [3:0]  s_lit;
    logic        use_lit, ts_zero, cond_nz;
    logic [15:0] result;
    logic        carry_next, carry_we, commit, carry_q;

    int errors = 0;
    int checks = 0;
    logic model_c;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    twoop_alu u_twoop_alu (
        .clk(clk), .rst(rst), .op(op), .d_val(d_val), .s_reg(s_reg),
        .s_lit(s_lit), .use_lit(use_lit), .ts_zero(ts_zero), .cond_nz(cond_nz),
        .result(result), .carry_next(carry_next), .carry_we(carry_we),
        .commit(commit), .carry_q(carry_q)
    );

    // Reference: returns {we, carry, value}
    function automatic logic [17:0] ref_alu(logic [3:0] o, logic [15:0] d,
                                            logic [15:0] s, logic c);
        logic [16:0] t;
        case (o)
            4'd0:  return {1'b0, c, 16'(d + s)};
            4'd1:  return {1'b0, c, 16'(d - s)};
            4'd2:  return {1'b0, c, s};
            4'd3:  return {1'b0, c, 16'(16'd0 - s)};
            4'd4:  begin t = {1'b0, d} + {1'b0, s}; return {1'b1, t[16], t[15:0]}; end
            4'd5:  return {1'b1, (d < s), 16'(d - s)};
            4'd6:  begin t = {1'b0, d} + {1'b0, s} + 17'(c); return {1'b1, t[16], t[15:0]}; end
            4'd7:  return {1'b1, (17'(d) < 17'(s) + 17'(c)), 16'(d - s - 16'(c))};
            4'd8:  return {1'b0, c, d & s};
            4'd9:  return {1'b0, c, d | s};
            4'd10: return {1'b0, c, d ^ s};
            4'd11: return {1'b0, c, ~s};
            4'd12: return {1'b0, c, c, s[15:1]};
            4'd13: return {1'b0, c, s[14:0], 1'b0};
            4'd14: return {1'b1, s[0], c, s[15:1]};
            default: return {1'b1, s[15], s[14:0], c};
        endcase
    endfunction

    function automatic string req_of(logic [3:0] o);
        if (o < 4'd4)  return "R2";
        if (o < 4'd6)  return "R3";
        if (o < 4'd8)  return "R4";
        if (o < 4'd12) return "R5";
        if (o < 4'd14) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation, check combinational outputs, clock it, check carry.
    task automatic run_op(logic [3:0] o, logic [15:0] d, logic [15:0] sr,
                          logic [3:0] sl, logic ul, logic tz, logic cn,
                          string tag);
        logic [15:0] s;
        logic [17:0] e;
        logic        cm;
        @(negedge clk);
        op = o; d_val = d; s_reg = sr; s_lit = sl; use_lit = ul;
        ts_zero = tz; cond_nz = cn;
        #1;
        s  = ul ? {12'd0, sl} : sr;
        e  = ref_alu(o, d, s, model_c);
        cm = cn ? !tz : tz;
        check(tag.len() > 0 ? tag : req_of(o),
              {carry_we, carry_next, result}, e);
        check("R9", {17'd0, commit}, {17'd0, cm});
        @(posedge clk);
        #1;
        if (cm && e[17]) model_c = e[16];
        check("R10", {17'd0, carry_q}, {17'd0, model_c});
    endtask

    initial begin
        #20000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        rst = 1'b1; op = 4'd0; d_val = '0; s_reg = '0; s_lit = '0;
        use_lit = 1'b0; ts_zero = 1'b1; cond_nz = 1'b0;
        model_c = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {17'd0, carry_q}, 18'd0);
        @(negedge clk); rst = 1'b0;

        // Directed corners
        run_op(4'd4, 16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b1, 1'b0, "R3");   // add overflow -> C=1
        run_op(4'd6, 16'h0000, 16'h0000, 4'd0, 1'b0, 1'b1, 1'b0, "R4");   // adc 0+0+1
        run_op(4'd5, 16'h0000, 16'h0001, 4'd0, 1'b0, 1'b1, 1'b0, "R3");   // sub borrow
        run_op(4'd7, 16'h0005, 16'h0004, 4'd0, 1'b0, 1'b1, 1'b0, "R4");   // sbb 5-4-1
        run_op(4'd14, 16'h0000, 16'h8001, 4'd0, 1'b0, 1'b1, 1'b0, "R7");  // rrc
        run_op(4'd12, 16'h0000, 16'h0002, 4'd0, 1'b0, 1'b1, 1'b0, "R6");  // sr pulls C
        run_op(4'd15, 16'h0000, 16'h8000, 4'd0, 1'b0, 1'b1, 1'b0, "R7");  // rlc
        run_op(4'd2, 16'h1234, 16'hFFFF, 4'hF, 1'b1, 1'b1, 1'b0, "R8");   // literal mov
        run_op(4'd0, 16'hFFF0, 16'hAAAA, 4'h9, 1'b1, 1'b0, 1'b1, "R8");   // literal adn
        // Failed condition: carry must hold
        run_op(4'd4, 16'hFFFF, 16'hFFFF, 4'd0, 1'b0, 1'b0, 1'b0, "R10");
        run_op(4'd5, 16'h0000, 16'h0001, 4'd0, 1'b0, 1'b1, 1'b1, "R10");
        run_op(4'd11, 16'h0000, 16'h00FF, 4'd0, 1'b0, 1'b1, 1'b0, "R5");
        run_op(4'd3, 16'h0000, 16'h0001, 4'd0, 1'b0, 1'b1, 1'b0, "R2");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            run_op(4'($urandom), 16'($urandom), 16'($urandom), 4'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), "");
        end

        // Reset clears a set carry
        run_op(4'd4, 16'hFFFF, 16'hFFFF, 4'd0, 1'b0, 1'b1, 1'b0, "R3");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", {17'd0, carry_q}, 18'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule